// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out one atomic memory instruction for each request from a small bytecode-style processor. Each request is already decoded. It carries an operand size, an 8-bit operation code, a base address, a signed offset, the source operand and the current value of register R0. The unit first adds the offset to the base. It then reads the memory word at that address and computes the update. If the operation calls for a store, it writes the new word back. The lock output is held the whole time, so no other agent can access memory between the read and the write.

When the operation is finished, the unit gives a single response pulse. The pulse carries the register writeback: the destination (none, the source register or R0) and a 64-bit value. It also carries a flag that marks a rejected request. A rejected request never touches memory and never writes a register. The operation code combines a base operation in the upper bits with a fetch modifier in bit 0. Compare-and-exchange takes R0 as an implicit operand.

Top module: `amo_exec`

## Requirements
- R1: `reqSize` encodes 2'b10 as 32-bit and 2'b11 as 64-bit. The codes 2'b00 (8-bit) and 2'b01 (16-bit) are rejected: the unit sets `rspIllegal`, makes no memory access, and gives the response in the first cycle after acceptance.
- R2: Op codes 0x00/0x01 (add), 0x40/0x41 (OR), 0x50/0x51 (AND) and 0xA0/0xA1 (XOR) store (old memory value op source) to the effective address. Add wraps modulo the operand width.
- R3: Bit 0 of the op code is the fetch modifier. For the four simple operations, a set bit gives `rspDest` = 2'd1 (source register) and returns the old memory value. A clear bit gives `rspDest` = 2'd0 (no writeback) and `rspData` = 0.
- R4: Exchange (0xE1) stores the source operand and returns the old memory value with `rspDest` = 2'd1.
- R5: Compare-and-exchange (0xF1) stores the source operand only when the memory value equals R0. A mismatch causes a single read access and no write. In both cases the response has `rspDest` = 2'd2 (R0) and the old value.
- R6: The codes 0xE0 and 0xF0, and any code not listed above, raise `rspIllegal` with `rspDest` = 2'd0, `rspData` = 0 and no memory access.
- R7: In 32-bit mode only bits 31:0 of memory, source and R0 take part. The compare uses only those bits, bits 63:32 of the memory word are written back unchanged, and the returned value is zero-extended to 64 bits.
- R8: The effective address is `reqBase` plus the sign-extended `reqOffset`, truncated to the address width.
- R9: `memLock` is high on every memory access. It stays high with a stable address from the read until the write completes, and no other access falls between the two.
- R10: `busy` rises in the cycle after a request is accepted and stays high through the response cycle. `reqValid` is ignored while `busy` is high.
- R11: `rspValid` is high for exactly one cycle for each accepted request.
- R12: After reset, `busy`, `memReq`, `memLock` and `rspValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqSize | input | 2 | Operand size code |
| reqOp | input | 8 | Operation code with fetch modifier in bit 0 |
| reqBase | input | 16 | Base address |
| reqOffset | input | 16 | Signed address offset |
| reqSrc | input | 64 | Source register value |
| reqR0 | input | 64 | Current R0 value |
| busy | output | 1 | Unit occupied; requests ignored |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memLock | output | 1 | Memory locked for the read-modify-write |
| memAddr | output | 16 | Access address |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid with memAck |
| memAck | input | 1 | Access completed |
| rspValid | output | 1 | Response pulse |
| rspIllegal | output | 1 | Request rejected |
| rspDest | output | 2 | Writeback target: 0 none, 1 source, 2 R0 |
| rspData | output | 64 | Writeback value |

## Verification
The unit decodes the op code into a stored operation kind. If that kind is decoded wrongly, the error shows at the ports within the same transaction: the stored word differs, or `rspDest` names the wrong register, and `rspData` carries the wrong value. A fault in the 32-bit masking shows in two ways. Bits 63:32 of the stored word change where they should be preserved, or a fetched value comes back without zero-extension. If the controller leaves the state sequence, the effect appears within a few cycles. The symptoms are a memory access without the lock, a second write, a missing or doubled response pulse, or `busy` dropping before the response. The bench counts accesses per transaction and compares every stored word against its own model.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    KIND_ADD, KIND_OR, KIND_AND, KIND_XOR, KIND_XCHG, KIND_CAS, KIND_BAD
  } kindT;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_SRC  = 2'd1,
    DEST_R0   = 2'd2
  } destT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_RESP
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;
    logic capOld;
    logic capNew;
  } strobeT;

  function automatic kindT decodeOp(input logic [7:0] op);
    case (op)
      8'h00, 8'h01: decodeOp = KIND_ADD;
      8'h40, 8'h41: decodeOp = KIND_OR;
      8'h50, 8'h51: decodeOp = KIND_AND;
      8'hA0, 8'hA1: decodeOp = KIND_XOR;
      8'hE1:        decodeOp = KIND_XCHG;
      8'hF1:        decodeOp = KIND_CAS;
      default:      decodeOp = KIND_BAD;
    endcase
  endfunction

endpackage

// File: rtl/amo_dpath.sv
module amo_dpath
  import amo_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic [1:0]    reqSize,
  input  logic [7:0]    reqOp,
  input  logic [AW-1:0] reqBase,
  input  logic [OW-1:0] reqOffset,
  input  logic [DW-1:0] reqSrc,
  input  logic [DW-1:0] reqR0,
  input  logic [DW-1:0] memRdata,
  output logic          reqIllegal,
  output logic          skipWrite,
  output logic          illegalHeld,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [1:0]    rspDest,
  output logic [DW-1:0] rspData
);
  localparam int HW = DW / 2;

  kindT          kindReg;
  logic          fetchReg, wideReg, illegalReg;
  logic [AW-1:0] addrReg;
  logic [DW-1:0] srcReg, r0Reg, oldReg, newReg;
  logic [DW-1:0] opA, opB, result, merged, oldExt;
  logic          casHit;
  destT          dest;

  assign reqIllegal = (decodeOp(reqOp) == KIND_BAD) || !reqSize[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindReg    <= KIND_BAD;
      fetchReg   <= 1'b0;
      wideReg    <= 1'b0;
      illegalReg <= 1'b0;
      addrReg    <= '0;
      srcReg     <= '0;
      r0Reg      <= '0;
      oldReg     <= '0;
      newReg     <= '0;
    end else begin
      if (strobe.capReq) begin
        kindReg    <= decodeOp(reqOp);
        fetchReg   <= reqOp[0];
        wideReg    <= reqSize[0];
        illegalReg <= reqIllegal;
        addrReg    <= reqBase + AW'(signed'(reqOffset));
        srcReg     <= reqSrc;
        r0Reg      <= reqR0;
      end
      if (strobe.capOld) oldReg <= memRdata;
      if (strobe.capNew) newReg <= merged;
    end
  end

  assign opA    = wideReg ? oldReg : {{HW{1'b0}}, oldReg[HW-1:0]};
  assign opB    = wideReg ? srcReg : {{HW{1'b0}}, srcReg[HW-1:0]};
  assign oldExt = opA;
  assign casHit = wideReg ? (oldReg == r0Reg) : (oldReg[HW-1:0] == r0Reg[HW-1:0]);

  always_comb begin
    case (kindReg)
      KIND_ADD: result = opA + opB;
      KIND_OR:  result = opA | opB;
      KIND_AND: result = opA & opB;
      KIND_XOR: result = opA ^ opB;
      default:  result = opB;
    endcase
  end

  // 32-bit mode keeps the upper half of the memory word
  assign merged = wideReg ? result : {oldReg[DW-1:HW], result[HW-1:0]};

  always_comb begin
    if (illegalReg)                                    dest = DEST_NONE;
    else if (kindReg == KIND_CAS)                      dest = DEST_R0;
    else if (kindReg == KIND_XCHG || fetchReg)         dest = DEST_SRC;
    else                                               dest = DEST_NONE;
  end

  assign skipWrite   = (kindReg == KIND_CAS) && !casHit;
  assign illegalHeld = illegalReg;
  assign memAddr     = addrReg;
  assign memWdata    = newReg;
  assign rspDest     = dest;
  assign rspData     = (dest == DEST_NONE) ? '0 : oldExt;

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqIllegal,
  input  logic   skipWrite,
  input  logic   memAck,
  output strobeT strobe,
  output logic   busy,
  output logic   memReq,
  output logic   memWe,
  output logic   memLock,
  output logic   rspValid
);
  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memLock   = 1'b0;
    rspValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = reqIllegal ? ST_RESP : ST_READ;
        end
      end
      ST_READ: begin
        memReq  = 1'b1;
        memLock = 1'b1;
        if (memAck) begin
          strobe.capOld = 1'b1;
          stateNext     = ST_CALC;
        end
      end
      ST_CALC: begin
        memLock       = 1'b1;
        strobe.capNew = 1'b1;
        stateNext     = skipWrite ? ST_RESP : ST_WRITE;
      end
      ST_WRITE: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memLock = 1'b1;
        if (memAck) stateNext = ST_RESP;
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/amo_exec.sv
module amo_exec
  import amo_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqSize,
  input  logic [7:0]    reqOp,
  input  logic [AW-1:0] reqBase,
  input  logic [OW-1:0] reqOffset,
  input  logic [DW-1:0] reqSrc,
  input  logic [DW-1:0] reqR0,
  output logic          busy,
  output logic          memReq,
  output logic          memWe,
  output logic          memLock,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memAck,
  output logic          rspValid,
  output logic          rspIllegal,
  output logic [1:0]    rspDest,
  output logic [DW-1:0] rspData
);
  strobeT strobe;
  logic   reqIllegal, skipWrite, illegalHeld;

  amo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIllegal(reqIllegal),
    .skipWrite(skipWrite), .memAck(memAck), .strobe(strobe), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memLock(memLock), .rspValid(rspValid)
  );

  amo_dpath #(.AW(AW), .OW(OW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSize(reqSize), .reqOp(reqOp),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqSrc(reqSrc), .reqR0(reqR0),
    .memRdata(memRdata), .reqIllegal(reqIllegal), .skipWrite(skipWrite),
    .illegalHeld(illegalHeld), .memAddr(memAddr), .memWdata(memWdata),
    .rspDest(rspDest), .rspData(rspData)
  );

  assign rspIllegal = rspValid && illegalHeld;

endmodule

// File: rtl/amo_exec_chk.sv
module amo_exec_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [1:0]    reqSize,
  input logic          busy,
  input logic          memReq,
  input logic          memLock,
  input logic [AW-1:0] memAddr,
  input logic          rspValid,
  input logic          rspIllegal,
  input logic [1:0]    rspDest
);
  AST_LOCK_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memLock); // R9
  AST_ADDR_STABLE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (memLock && $past(memLock)) |-> $stable(memAddr)); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R11
  AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy); // R10
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R10
  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspIllegal) |-> (rspDest == 2'd0)); // R6
  AST_SMALL_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !reqSize[1]) |=> (rspValid && rspIllegal && !memReq)); // R1
endmodule

bind amo_exec amo_exec_chk #(.AW(AW)) u_chk (.*);

// File: tb/amo_exec_bench.sv
module amo_exec_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSize = 2'b11;
  logic [7:0]  reqOp = 8'h00;
  logic [15:0] reqBase = '0, reqOffset = '0;
  logic [63:0] reqSrc = '0, reqR0 = '0;
  logic        busy, memReq, memWe, memLock, memAck, rspValid, rspIllegal;
  logic [15:0] memAddr;
  logic [63:0] memWdata, memRdata;
  logic [1:0]  rspDest;
  logic [63:0] rspData;

  int checks = 0, errors = 0;
  int accessCount = 0, lockErrs = 0;
  logic [15:0] lastAddr;
  logic [63:0] mem [16];
  logic [63:0] shadow [16];

  always #10 clk = ~clk;

  amo_exec u_amo_exec (.*);

  // memory model: one-cycle acknowledge
  initial memAck = 1'b0;
  initial memRdata = '0;
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      accessCount++;
      if (!memLock) lockErrs++;
      lastAddr <= memAddr;
      memRdata <= mem[memAddr[3:0]];
      if (memWe) mem[memAddr[3:0]] <= memWdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isLegalOp(input logic [7:0] op);
    case (op)
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runOp(input logic [1:0] sz, input logic [7:0] op, input logic [15:0] base,
                       input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0);
    logic [15:0] addr;
    logic [63:0] old, a, b, r, expNew, expData;
    logic [1:0]  expDest;
    bit bad, wide, hit;
    int expAcc, waitCnt;
    addr = base + off;
    old  = shadow[addr[3:0]];
    wide = (sz == 2'b11);
    bad  = !sz[1] || !isLegalOp(op);
    a = wide ? old : {32'h0, old[31:0]};
    b = wide ? src : {32'h0, src[31:0]};
    hit = wide ? (old == r0) : (old[31:0] == r0[31:0]);
    case (op[7:4])
      4'h0: r = a + b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'hA: r = a ^ b;
      default: r = b;
    endcase
    if (!wide) r = {old[63:32], r[31:0]};
    expNew = old; expDest = 2'd0; expData = '0; expAcc = 2;
    if (bad) expAcc = 0;
    else if (op == 8'hF1) begin
      expDest = 2'd2; expData = a;
      if (hit) expNew = r; else expAcc = 1;
    end else begin
      expNew = r;
      if (op[0]) begin expDest = 2'd1; expData = a; end
    end
    accessCount = 0;
    reqSize = sz; reqOp = op; reqBase = base; reqOffset = off; reqSrc = src; reqR0 = r0;
    reqValid = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
    if (!rspValid) begin
      // R10: a different request held while busy must be ignored
      reqOp = 8'h01; reqSize = 2'b11; reqSrc = 64'hDEAD_BEEF_0000_0001;
      reqBase = base + 16'd3;
    end
    waitCnt = 0;
    while (!rspValid && waitCnt < 100) begin
      @(negedge clk);
      waitCnt++;
    end
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R11 response arrives", 64'(rspValid), 64'd1);
    check(rspIllegal == bad, bad ? "R1/R6 illegal flag" : "R6 legal not flagged", 64'(rspIllegal), 64'(bad));
    check(rspDest == expDest, "R3/R4/R5 writeback target", 64'(rspDest), 64'(expDest));
    check(rspData == expData, "R3/R5/R7 writeback value", rspData, expData);
    @(negedge clk);
    check(rspValid == 1'b0, "R11 single-cycle response", 64'(rspValid), 64'd0);
    check(busy == 1'b0, "R10 busy released", 64'(busy), 64'd0);
    check(mem[addr[3:0]] == expNew, "R2/R4/R5/R7 stored word", mem[addr[3:0]], expNew);
    check(accessCount == expAcc, "R9 access count", 64'(accessCount), 64'(expAcc));
    if (expAcc > 0)
      check(lastAddr == addr, "R8 effective address", 64'(lastAddr), 64'(addr));
    for (int i = 0; i < 16; i++)
      if (mem[i] != shadow[i] && i != int'(addr[3:0]))
        check(1'b0, "R10 untouched word changed", mem[i], shadow[i]);
    shadow[addr[3:0]] = expNew;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [14];
    logic [63:0] s, z;
    logic [15:0] bs, of;
    logic [1:0] sz;
    ops = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1,
            8'hE1, 8'hF1, 8'hE0, 8'hF0, 8'h02, 8'h61};
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) begin
      mem[i] = {$urandom, $urandom};
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy == 1'b0 && memReq == 1'b0 && memLock == 1'b0 && rspValid == 1'b0,
          "R12 reset outputs", {busy, memReq, memLock, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && rspValid == 1'b0, "R12 idle after reset", {busy, rspValid}, 64'd0);

    // directed corners
    mem[2] = 64'hFFFF_FFFF_FFFF_FFFF; shadow[2] = mem[2];
    runOp(2'b11, 8'h01, 16'd2, 16'd0, 64'd1, 64'd0);              // R2 64-bit wrap
    mem[3] = 64'h1234_5678_FFFF_FFFF; shadow[3] = mem[3];
    runOp(2'b10, 8'h01, 16'd3, 16'd0, 64'hAAAA_0000_0000_0001, 0); // R7 no carry upward
    runOp(2'b10, 8'h00, 16'd3, 16'd0, 64'h5, 0);                   // R3 no fetch
    runOp(2'b11, 8'hE1, 16'd4, 16'd0, 64'h0123_4567_89AB_CDEF, 0); // R4
    runOp(2'b11, 8'hF1, 16'd5, 16'd0, 64'h77, shadow[5]);          // R5 hit
    runOp(2'b11, 8'hF1, 16'd5, 16'd0, 64'h88, ~shadow[5]);         // R5 miss
    runOp(2'b10, 8'hF1, 16'd6, 16'd0, 64'h99, {32'hFFFF_0000, shadow[6][31:0]}); // R7 low compare
    runOp(2'b00, 8'h01, 16'd7, 16'd0, 64'h1, 0);                   // R1 8-bit
    runOp(2'b01, 8'h41, 16'd7, 16'd0, 64'h1, 0);                   // R1 16-bit
    runOp(2'b11, 8'hE0, 16'd8, 16'd0, 64'h1, 0);                   // R6 no fetch bit
    runOp(2'b11, 8'hF0, 16'd8, 16'd0, 64'h1, shadow[8]);           // R6
    runOp(2'b11, 8'h41, 16'd2, 16'hFFF5, 64'hF0, 0);               // R8 negative offset wraps

    // constrained random
    for (int n = 0; n < 300; n++) begin
      sz = ($urandom % 8 == 0) ? 2'($urandom % 2) : {1'b1, 1'($urandom % 2)};
      bs = 16'($urandom % 64);
      of = 16'($signed($urandom % 64) - 32);
      s  = {$urandom, $urandom};
      z  = {$urandom, $urandom};
      if ($urandom % 2 == 1) z = shadow[4'(bs + of)];
      runOp(sz, ops[$urandom % 14], bs, of, s, z);
    end
    check(lockErrs == 0, "R9 lock held on access", 64'(lockErrs), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule